// File: doc/BRIEF.md
# Iterative Fixed-Point Square Root Engine

This block returns the square root of one non-negative signed fixed-point sample at a time. The sample is a 16-bit word with 10 fraction bits, and the result uses the same format. The arithmetic is hyperbolic-vectoring CORDIC built only from shifts and adds. A single shift-add kernel runs every rotation in turn. A Moore controller sequences the work through three phases: normalizing the operand, running the shared loop, and rescaling the result back to the input format.

Samples arrive on a valid/ready stream and leave on a second one. The engine takes one sample, drops its input ready for the whole computation, and presents the result until the consumer accepts it. It arms again one cycle later. The latency from the accepting edge to a valid result is fixed at 24 cycles: 5 for normalization, 17 rotations, and 2 for pre-scaling and rescaling. Zero takes the same path as any other value.

Top module: `csqrt_unit`

## Requirements
- R1: For every input value from 0x0001 to 0x7FFF, the result (16 bits, signed, 10 fraction bits) lies within 2 LSB of the exact square root. The exact root is sqrt(in_data * 1024) in output LSB units.
- R2: An input of 0x0000 yields a result of exactly 0x0000.
- R3: out_valid first rises exactly 24 clock edges after the edge on which in_valid and in_ready were both high. No multiplier is used: the rotations use shifts 1 to 15, with shifts 4 and 13 each run twice.
- R4: Once a sample is accepted, in_ready stays low until the result has been taken. Any in_valid/in_data offered in the meantime is ignored, and the result belongs to the accepted sample.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R6: On the cycle after an output handshake, out_valid is low and in_ready is high.
- R7: in_ready and out_valid are never high in the same cycle.
- R8: A low rst_n sampled on a clock edge returns the engine to idle, with in_ready high and out_valid low. This includes a reset in the middle of a computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Engine idle and able to take a sample |
| in_data | input | 16 | Operand, signed, 10 fraction bits, non-negative |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 16 | Square root, signed, 10 fraction bits |

## Verification
The two functions that can land in the same cycle are result delivery and the offer of a new sample. During that cycle in_ready is still low, so the new sample must be dropped. The bench provokes this by holding in_valid high, with unrelated data, through the whole computation and across the output handshake. It then checks two things: the delivered root matches the sample actually accepted, and in_ready returns only on the following cycle, before any new sample can be taken. The same runs also hold out_ready low for some cycles, to show that delivery waits while the held result stays fixed.

// File: rtl/csqrt_pkg.sv
// Shared types and constant functions for the square root engine.
package csqrt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM,
        ST_PRE,
        ST_ITER,
        ST_POST,
        ST_DONE
    } csqrt_state_e;

    // Number of hyperbolic rotations for shifts 1..max_shift, where shifts
    // 4, 13, 40, ... are each run twice to keep the method convergent.
    function automatic int hyp_iter_count(input int max_shift);
        int n;
        int rep;
        n   = 0;
        rep = 4;
        for (int k = 1; k <= max_shift; k++) begin
            n++;
            if (k == rep) begin
                n++;
                rep = 3 * rep + 1;
            end
        end
        return n;
    endfunction

    // Shift amount used by rotation number idx (0-based) in the schedule above.
    function automatic int hyp_shift_at(input int idx);
        int n;
        int rep;
        n   = 0;
        rep = 4;
        for (int k = 1; k < 64; k++) begin
            if (n == idx) return k;
            n++;
            if (k == rep) begin
                if (n == idx) return k;
                n++;
                rep = 3 * rep + 1;
            end
        end
        return 63;
    endfunction

endpackage

// File: rtl/csqrt_ctrl.sv
// Moore sequencer for the square root engine.
// Walks idle -> normalize -> pre-scale -> rotate -> rescale -> hold result.
// Assumes NORM_CYC and ITERS are both at least 1 and fit in CW bits.
module csqrt_ctrl
    import csqrt_pkg::*;
#(
    parameter int NORM_CYC = 5,
    parameter int ITERS    = 17,
    parameter int CW       = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          out_ready,
    output logic          in_ready,
    output logic          out_valid,
    output logic          load,
    output logic          norm_en,
    output logic          pre_en,
    output logic          iter_en,
    output logic          post_en,
    output logic [CW-1:0] step
);

    localparam logic [CW-1:0] NORM_LAST = CW'(NORM_CYC - 1);
    localparam logic [CW-1:0] ITER_LAST = CW'(ITERS - 1);

    csqrt_state_e  state;
    logic [CW-1:0] cnt;

    // State register and phase counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        state <= ST_NORM;
                        cnt   <= '0;
                    end
                end
                ST_NORM: begin
                    if (cnt == NORM_LAST) begin
                        state <= ST_PRE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PRE: begin
                    state <= ST_ITER;
                    cnt   <= '0;
                end
                ST_ITER: begin
                    if (cnt == ITER_LAST) begin
                        state <= ST_POST;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_POST: state <= ST_DONE;
                ST_DONE: begin
                    if (out_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state alone (plus the input handshake strobe).
    always_comb begin
        in_ready  = (state == ST_IDLE);
        out_valid = (state == ST_DONE);
        load      = in_ready && in_valid;
        norm_en   = (state == ST_NORM);
        pre_en    = (state == ST_PRE);
        iter_en   = (state == ST_ITER);
        post_en   = (state == ST_POST);
        step      = cnt;
    end

endmodule

// File: rtl/csqrt_norm.sv
// Operand normalizer: shifts the operand left by an even count, in binary-search
// steps of WL/2, WL/4, ..., 2, until one of its top two bits is set.
// Assumes WL is a power of two and the operand is non-negative.
module csqrt_norm #(
    parameter int WL = 16,
    parameter int CW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 norm_en,
    input  logic [CW-1:0]        step,
    input  logic [WL-1:0]        in_data,
    output logic [WL-1:0]        nr,
    output logic [$clog2(WL)-1:0] scnt,
    output logic                 is_zero
);

    localparam int SW    = $clog2(WL);
    localparam int NSTEP = SW - 1;

    int   amt;
    logic top_zero;

    // Shift amount for this step and whether the top bits it would drop are zero.
    always_comb begin
        amt = 0;
        if (int'(step) < NSTEP) amt = 1 << (NSTEP - int'(step));
        top_zero = (amt != 0) && ((nr >> (WL - amt)) == '0);
    end

    // Operand capture and conditional left shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nr      <= '0;
            scnt    <= '0;
            is_zero <= 1'b0;
        end else if (load) begin
            nr      <= in_data;
            scnt    <= '0;
            is_zero <= (in_data == '0);
        end else if (norm_en && top_zero) begin
            nr   <= nr << amt;
            scnt <= scnt + SW'(amt);
        end
    end

endmodule

// File: rtl/csqrt_kernel.sv
// Shared hyperbolic-vectoring shift-add kernel.
// Pre-scale: x = (v + 1/4) / K, y = (v - 1/4) / K, where v = nr / 2^WL.
// Each rotation drives y toward zero; x then converges to sqrt(v).
// Assumes v lies in [1/4, 1) with FW fraction bits held in XW signed bits.
module csqrt_kernel
    import csqrt_pkg::*;
#(
    parameter int WL    = 16,
    parameter int FW    = 20,
    parameter int XW    = 24,
    parameter int ITERS = 17,
    parameter int CW    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pre_en,
    input  logic                 iter_en,
    input  logic [CW-1:0]        step,
    input  logic [WL-1:0]        nr,
    output logic signed [XW-1:0] x
);

    localparam int SHW = $clog2(WL);
    localparam logic signed [XW-1:0] QTR = XW'(1) <<< (FW - 2);

    // Multiplier-free 1/K (about 1.2075) as a sum of shifted copies.
    function automatic logic signed [XW-1:0] inv_gain(input logic signed [XW-1:0] a);
        return a + (a >>> 3) + (a >>> 4) + (a >>> 6) + (a >>> 8) + (a >>> 11);
    endfunction

    logic [SHW-1:0]        sh_tab [ITERS];
    logic [SHW-1:0]        sh;
    logic signed [XW-1:0]  y;
    logic signed [XW-1:0]  vw;
    logic signed [XW-1:0]  xs;
    logic signed [XW-1:0]  ys;

    for (genvar g = 0; g < ITERS; g++) begin : g_sched
        assign sh_tab[g] = SHW'(hyp_shift_at(g));
    end

    // Select the shift of the current rotation and form shifted operands.
    always_comb begin
        sh = '0;
        for (int i = 0; i < ITERS; i++) begin
            if (int'(step) == i) sh = sh_tab[i];
        end
        vw = XW'(nr) <<< (FW - WL);
        xs = x >>> sh;
        ys = y >>> sh;
    end

    // Pre-scale load, then one rotation per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x <= '0;
            y <= '0;
        end else if (pre_en) begin
            x <= inv_gain(vw + QTR);
            y <= inv_gain(vw - QTR);
        end else if (iter_en) begin
            if (y[XW-1]) begin
                x <= x + ys;
                y <= y + xs;
            end else begin
                x <= x - ys;
                y <= y - xs;
            end
        end
    end

endmodule

// File: rtl/csqrt_scale.sv
// Output rescaler: undoes the normalization (half the shift count) and rounds
// the kernel result to FL fraction bits; holds the value until the next load.
// Assumes WL - FL is even and x is non-negative.
module csqrt_scale #(
    parameter int WL = 16,
    parameter int FL = 10,
    parameter int FW = 20,
    parameter int XW = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  post_en,
    input  logic signed [XW-1:0]  x,
    input  logic [$clog2(WL)-1:0] scnt,
    input  logic                  is_zero,
    output logic [WL-1:0]         out_data
);

    localparam int RSH0 = FW - FL - (WL - FL) / 2;

    int            rsh;
    logic [XW-1:0] sum;

    // Right shift amount and rounding bias.
    always_comb begin
        rsh = RSH0 + int'(scnt >> 1);
        sum = x + (XW'(1) << (rsh - 1));
    end

    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
        end else if (post_en) begin
            out_data <= is_zero ? '0 : WL'(sum >> rsh);
        end
    end

endmodule

// File: rtl/csqrt_unit.sv
// Square root engine top: sequencer, normalizer, shared kernel and rescaler.
// One sample in flight; fixed latency NORM_CYC + ITERS + 2 cycles.
// Assumes WL is a power of two, WL - FL is even, operands are non-negative.
module csqrt_unit
    import csqrt_pkg::*;
#(
    parameter int WL = 16,
    parameter int FL = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [WL-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [WL-1:0] out_data
);

    localparam int SW       = $clog2(WL);
    localparam int NORM_CYC = SW + 1;
    localparam int ITERS    = hyp_iter_count(WL - 1);
    localparam int CW       = $clog2((ITERS > NORM_CYC ? ITERS : NORM_CYC) + 1);
    localparam int FW       = WL + 4;
    localparam int XW       = FW + 4;

    logic                 load, norm_en, pre_en, iter_en, post_en;
    logic [CW-1:0]        step;
    logic [WL-1:0]        nr;
    logic [SW-1:0]        scnt;
    logic                 is_zero;
    logic signed [XW-1:0] x;

    csqrt_ctrl #(.NORM_CYC(NORM_CYC), .ITERS(ITERS), .CW(CW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid), .load(load),
        .norm_en(norm_en), .pre_en(pre_en), .iter_en(iter_en),
        .post_en(post_en), .step(step)
    );

    csqrt_norm #(.WL(WL), .CW(CW)) norm_i (
        .clk(clk), .rst_n(rst_n), .load(load), .norm_en(norm_en),
        .step(step), .in_data(in_data), .nr(nr), .scnt(scnt),
        .is_zero(is_zero)
    );

    csqrt_kernel #(.WL(WL), .FW(FW), .XW(XW), .ITERS(ITERS), .CW(CW)) kern_i (
        .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .iter_en(iter_en),
        .step(step), .nr(nr), .x(x)
    );

    csqrt_scale #(.WL(WL), .FL(FL), .FW(FW), .XW(XW)) scale_i (
        .clk(clk), .rst_n(rst_n), .post_en(post_en), .x(x), .scnt(scnt),
        .is_zero(is_zero), .out_data(out_data)
    );

endmodule

// File: rtl/csqrt_unit_chk.sv
// Protocol and timing checker for csqrt_unit, attached by bind.
module csqrt_unit_chk
    import csqrt_pkg::*;
#(
    parameter int WL = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [WL-1:0] in_data,
    input logic          out_valid,
    input logic          out_ready,
    input logic [WL-1:0] out_data
);

    localparam int LAT = $clog2(WL) + 1 + hyp_iter_count(WL - 1) + 2;

    int   lat_cnt;
    logic zero_pend;

    // Cycles since the last accepted sample, and whether it was zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cnt   <= 0;
            zero_pend <= 1'b0;
        end else if (in_valid && in_ready) begin
            lat_cnt   <= 0;
            zero_pend <= (in_data == '0);
        end else if (lat_cnt < 1000) begin
            lat_cnt <= lat_cnt + 1;
        end
    end

    // R3: result appears exactly LAT edges after acceptance.
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (lat_cnt == LAT));

    // R2: zero operand gives zero result.
    p_zero_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(out_valid) && zero_pend) |-> (out_data == '0));

    // R4: no further acceptance right after a sample is taken.
    p_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R5: result held under back-pressure.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R6: re-armed one cycle after delivery.
    p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    // R7: idle and result-valid are exclusive.
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R8: reset lands in idle.
    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> (in_ready && !out_valid));

endmodule

bind csqrt_unit csqrt_unit_chk #(.WL(WL)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
);

// File: tb/csqrt_unit_tb_top.sv
// Bench for csqrt_unit: near-exhaustive operand sweep against a real-valued root.
module csqrt_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [15:0] in_data;
    logic        out_valid;
    logic        out_ready;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    int overlap = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    csqrt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    // R7 monitor: count cycles with both flags high.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && in_ready === 1'b1 && out_valid === 1'b1) overlap++;
    end

    task automatic chk(input bit ok, input string req, input real act, input real exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One transaction: offer d, optionally keep offering noise, stall the output.
    task automatic xact(input logic [15:0] d, input int hold, input bit noisy);
        int   n;
        int   busy_bad;
        int   hold_bad;
        real  e;
        logic [15:0] got;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        if (noisy) in_data = (d ^ 16'h2A55) & 16'h7FFF;
        else in_valid = 1'b0;
        n = 1;
        busy_bad = 0;
        while (!out_valid && n < 40) begin
            if (in_ready) busy_bad++;
            @(negedge clk);
            n++;
        end
        chk(n - 1 == 24, "R3 latency", real'(n - 1), 24.0);
        chk(busy_bad == 0, "R4 ready low while busy", real'(busy_bad), 0.0);
        got = out_data;
        e = $sqrt(real'(d) * 1024.0);
        if (d == 0)
            chk(got == 16'h0000, "R2 zero root", real'(got), 0.0);
        else
            chk(((real'(got) - e) <= 2.0) && ((e - real'(got)) <= 2.0),
                noisy ? "R4 root of accepted sample" : "R1 root value", real'(got), e);
        hold_bad = 0;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            if (!out_valid || out_data != got || in_ready) hold_bad++;
        end
        if (hold > 0) chk(hold_bad == 0, "R5 held under stall", real'(hold_bad), 0.0);
        out_ready = 1'b1;
        @(negedge clk);
        chk(in_ready && !out_valid, "R6 rearm after delivery",
            real'({in_ready, out_valid}), 2.0);
        out_ready = 1'b0;
        in_valid  = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(in_ready && !out_valid, "R8 reset state", real'({in_ready, out_valid}), 2.0);
        rst_n = 1'b1;

        // Specific values, including exact roots and extremes.
        xact(16'd0, 0, 1'b0);
        xact(16'd1024, 1, 1'b0);
        xact(16'd4096, 0, 1'b1);
        xact(16'd1, 0, 1'b0);
        xact(16'h7FFF, 3, 1'b1);

        // Reset in the middle of a computation (R8).
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'd5000;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(in_ready && !out_valid, "R8 reset mid computation",
            real'({in_ready, out_valid}), 2.0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(in_ready && !out_valid, "R8 no result after reset",
            real'({in_ready, out_valid}), 2.0);

        // Every small operand, every shift class.
        for (int v = 1; v < 256; v++) xact(16'(v), 0, 1'b0);
        // Stride sweep across the range, alternating noise and stalls.
        for (int v = 0; v < 32768; v += 16)
            xact(16'(v), (v % 64 == 0) ? 2 : 0, (v % 32) == 16);
        for (int v = 32760; v < 32768; v++) xact(16'(v), 0, 1'b1);

        chk(overlap == 0, "R7 ready and valid exclusive", real'(overlap), 0.0);
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

endmodule